// File: doc/BRIEF.md
# Power-Management Event and Timer Unit

This block holds a 16-bit power-management status register and a matching 16-bit enable register. Alongside them runs a free-running counter whose low 24 bits form a power-management timer. A small bus slave port reads and writes the two registers and reads the timer count. Hardware events set status bits: wake requests from three kinds of source, a power-button request, and the timer crossing its next overflow boundary. Software clears a status bit by writing a 1 to it.

The block drives a level-sensitive system control interrupt. The interrupt is high while any enabled status bit inside the common event mask is set, or while the general-purpose event term from a neighbouring block is high. The counter advances only in cycles where the tick-enable input is high, so the timer rate is set by the clock divider that drives that input. After a write clears the timer status, the overflow boundary moves to the multiple of the step that follows the current count, so each overflow can raise the timer status once.

Top module: `pm_event_timer`

## Requirements
- R1: The bus decodes status at byte offset 0 and enable at offset 2, and accepts only 16-bit accesses there (bus_size 2'b01, data on bits 15:0). The timer sits at offset 8 and is read only with a 32-bit access (bus_size 2'b10). An access to any other offset, or of the wrong size, reads 0, and a write of that kind changes nothing.
- R2: A write to status clears every bit written as 1 and leaves every bit written as 0 unchanged.
- R3: A write to enable stores all 16 bits of the data, and reading enable returns what was stored.
- R4: A timer read returns zeros in bits 31:24 and the low 24 bits of the counter in bits 23:0. The counter adds one on each clock edge where tick_en is high, and writes to offset 8 are ignored.
- R5: Timer status (bit 0) is set on the edge after the counter becomes equal to or greater than the overflow point. After reset the overflow point is one step, 2^BOUND_LOG2 (default 0x800000).
- R6: A write that clears timer status while it is set moves the overflow point to the current count rounded up to the next multiple of the step. A boundary the counter has already passed then raises no new status.
- R7: A one-cycle wake_req sets wake status (bit 15) together with a source bit selected by wake_src: 0 selects RTC status (bit 10), 1 selects timer status (bit 0), and 2 or 3 select power-button status (bit 8).
- R8: pwrbtn_req sets power-button status (bit 8) only while power-button enable (enable bit 8) is set. Otherwise it changes nothing.
- R9: sci is high exactly when (status AND enable AND 16'h0721) is nonzero, or when gpe_evt is high. The mask covers bits 0, 5, 8, 9 and 10, so wake status alone never raises sci.
- R10: Reset clears status, enable and the counter, and returns the overflow point to one step.
- R11: When a hardware event sets a status bit in the same cycle that a write clears it, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Counter advance enable |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset |
| bus_size | input | 2 | 2'b01 = 16-bit, 2'b10 = 32-bit |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| wake_req | input | 1 | Wake event pulse |
| wake_src | input | 2 | Wake source: 0 RTC, 1 timer, 2/3 other |
| pwrbtn_req | input | 1 | Power-button request pulse |
| gpe_evt | input | 1 | General-purpose event term |
| sci | output | 1 | System control interrupt level |

## Verification
The hardest case to reach is the timer overflow and what follows it. At the default step the counter needs millions of ticks before it crosses a boundary. The bench therefore builds the block with a step of 64 and moves the counter with counted bursts of tick_en. It then checks the status one tick short of the boundary and at the boundary. It clears the status well past the boundary, which must move the overflow point to 128 instead of setting the status again at once. It also drives a wake event and a clearing write into the same cycle to check which one wins.

// File: rtl/pm_event_timer.sv
module pm_event_timer #(
  parameter int CNT_W      = 32,
  parameter int TMR_W      = 24,
  parameter int BOUND_LOG2 = 23,
  parameter int ADDR_W     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_size,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              wake_req,
  input  logic [1:0]        wake_src,
  input  logic              pwrbtn_req,
  input  logic              gpe_evt,
  output logic              sci
);

  localparam logic [CNT_W-1:0] STEP     = CNT_W'(1) << BOUND_LOG2;
  localparam logic [CNT_W-1:0] LOW_MASK = STEP - CNT_W'(1);
  localparam logic [15:0]      SCI_MASK = 16'h0721;
  localparam int B_TMR = 0;
  localparam int B_PWR = 8;
  localparam int B_RTC = 10;
  localparam int B_WAK = 15;
  localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_EN  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_TMR = ADDR_W'(8);

  logic [15:0]      sts, en, set_bits, clr_bits;
  logic [CNT_W-1:0] cnt, ovf_pt;

  wire acc16  = bus_sel && (bus_size == 2'b01);
  wire acc32  = bus_sel && (bus_size == 2'b10);
  wire sts_wr = acc16 && bus_wr && (bus_addr == A_STS);
  wire en_wr  = acc16 && bus_wr && (bus_addr == A_EN);

  assign clr_bits = sts_wr ? bus_wdata[15:0] : 16'h0000;

  wire rearm   = clr_bits[B_TMR] && sts[B_TMR];
  wire ovf_hit = (cnt >= ovf_pt) && !rearm;

  always_comb begin
    set_bits = 16'h0000;
    if (ovf_hit) set_bits[B_TMR] = 1'b1;
    if (wake_req) begin
      set_bits[B_WAK] = 1'b1;
      case (wake_src)
        2'd0:    set_bits[B_RTC] = 1'b1;
        2'd1:    set_bits[B_TMR] = 1'b1;
        default: set_bits[B_PWR] = 1'b1;
      endcase
    end
    if (pwrbtn_req && en[B_PWR]) set_bits[B_PWR] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sts    <= '0;
      en     <= '0;
      cnt    <= '0;
      ovf_pt <= STEP;
    end else begin
      sts <= (sts & ~clr_bits) | set_bits;
      if (en_wr)   en  <= bus_wdata[15:0];
      if (tick_en) cnt <= cnt + CNT_W'(1);
      if (rearm)   ovf_pt <= (cnt + STEP) & ~LOW_MASK;
    end
  end

  always_comb begin
    bus_rdata = 32'h0;
    if (bus_sel && !bus_wr) begin
      if (acc16 && bus_addr == A_STS)      bus_rdata = {16'h0, sts};
      else if (acc16 && bus_addr == A_EN)  bus_rdata = {16'h0, en};
      else if (acc32 && bus_addr == A_TMR) bus_rdata = 32'(cnt[TMR_W-1:0]);
    end
  end

  assign sci = (|(sts & en & SCI_MASK)) || gpe_evt;

  a_r2_clear_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_wr && bus_wdata[B_WAK] && !wake_req) |=> !sts[B_WAK]);

  a_r3_enable_store: assert property (@(posedge clk) disable iff (!rst_n)
    en_wr |=> (en == $past(bus_wdata[15:0])));

  a_r4_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> (cnt == $past(cnt)));

  a_r6_rearm_ahead: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sts[B_TMR]) |-> (ovf_pt > cnt));

  a_r7_rtc_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_req && wake_src == 2'd0) |=> (sts[B_WAK] && sts[B_RTC]));

  a_r8_pwrbtn_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (pwrbtn_req && !en[B_PWR] && !wake_req && !sts_wr) |=> (sts[B_PWR] == $past(sts[B_PWR])));

endmodule

// File: tb/sim_pm_event_timer.sv
module sim_pm_event_timer;
  logic clk = 1'b0, rst_n = 1'b0, tick_en = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [1:0] bus_size = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic wake_req = 1'b0, pwrbtn_req = 1'b0, gpe_evt = 1'b0, sci;
  logic [1:0] wake_src = '0;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pm_event_timer #(.BOUND_LOG2(6)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wake_req(wake_req), .wake_src(wake_src), .pwrbtn_req(pwrbtn_req),
    .gpe_evt(gpe_evt), .sci(sci));

  typedef struct packed {
    logic        wr;
    logic [3:0]  waddr;
    logic [1:0]  wsize;
    logic [31:0] wdata;
    logic [3:0]  raddr;
    logic [1:0]  rsize;
    logic [31:0] exp;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{1'b1, 4'd2, 2'b01, 32'h0000_0521, 4'd2, 2'b01, 32'h0000_0521},
    '{1'b1, 4'd2, 2'b10, 32'h0000_ABCD, 4'd2, 2'b01, 32'h0000_0521},
    '{1'b1, 4'd0, 2'b01, 32'h0000_FFFF, 4'd0, 2'b01, 32'h0000_0000},
    '{1'b1, 4'd8, 2'b10, 32'h1234_5678, 4'd8, 2'b10, 32'h0000_0000},
    '{1'b0, 4'd0, 2'b01, 32'h0000_0000, 4'd4, 2'b01, 32'h0000_0000},
    '{1'b1, 4'd2, 2'b01, 32'h0000_0000, 4'd2, 2'b01, 32'h0000_0000},
    '{1'b1, 4'd2, 2'b01, 32'h0000_7E3C, 4'd2, 2'b10, 32'h0000_0000},
    '{1'b1, 4'd2, 2'b01, 32'h0000_FFFF, 4'd2, 2'b01, 32'h0000_FFFF}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_size = s; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [1:0] s, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; bus_size = s;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic wake(input logic [1:0] src);
    @(negedge clk);
    wake_req = 1'b1; wake_src = src;
    @(negedge clk);
    wake_req = 1'b0;
  endtask

  task automatic tick_n(input int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(posedge clk);
    @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    rd(4'd0, 2'b01, d); check("R10 status after reset", d, 32'h0);
    rd(4'd2, 2'b01, d); check("R10 enable after reset", d, 32'h0);
    rd(4'd8, 2'b10, d); check("R10 timer after reset", d, 32'h0);
    check("R9 sci after reset", {31'b0, sci}, 32'h0);

    // R1 R3 R4: decode, size and readback vectors
    for (int i = 0; i < 8; i++) begin
      if (VEC[i].wr) wr(VEC[i].waddr, VEC[i].wsize, VEC[i].wdata);
      rd(VEC[i].raddr, VEC[i].rsize, d);
      check($sformatf("R1/R3 vector %0d", i), d, VEC[i].exp);
    end

    wr(4'd2, 2'b01, 32'h0);
    wake(2'd0);
    rd(4'd0, 2'b01, d); check("R7 rtc wake", d, 32'h8400);
    check("R9 sci masked off", {31'b0, sci}, 32'h0);
    wr(4'd2, 2'b01, 32'h8000);
    check("R9 wake bit outside mask", {31'b0, sci}, 32'h0);
    wr(4'd2, 2'b01, 32'h0400);
    check("R9 rtc enabled raises sci", {31'b0, sci}, 32'h1);
    wr(4'd0, 2'b01, 32'h0400);
    rd(4'd0, 2'b01, d); check("R2 clear only written bit", d, 32'h8000);
    check("R9 sci drops after clear", {31'b0, sci}, 32'h0);
    wr(4'd0, 2'b01, 32'h8000);
    rd(4'd0, 2'b01, d); check("R2 wake bit cleared", d, 32'h0);

    wake(2'd1);
    rd(4'd0, 2'b01, d); check("R7 timer wake", d, 32'h8001);
    wr(4'd0, 2'b01, 32'hFFFF);
    wake(2'd3);
    rd(4'd0, 2'b01, d); check("R7 other wake", d, 32'h8100);
    wr(4'd0, 2'b01, 32'hFFFF);

    wr(4'd2, 2'b01, 32'h0);
    @(negedge clk) pwrbtn_req = 1'b1;
    @(negedge clk) pwrbtn_req = 1'b0;
    rd(4'd0, 2'b01, d); check("R8 button ignored when disabled", d, 32'h0);
    wr(4'd2, 2'b01, 32'h0100);
    @(negedge clk) pwrbtn_req = 1'b1;
    @(negedge clk) pwrbtn_req = 1'b0;
    rd(4'd0, 2'b01, d); check("R8 button latched when enabled", d, 32'h0100);
    check("R9 sci from button", {31'b0, sci}, 32'h1);
    wr(4'd0, 2'b01, 32'hFFFF);
    wr(4'd2, 2'b01, 32'h0);

    @(negedge clk) gpe_evt = 1'b1;
    #1 check("R9 gpe term raises sci", {31'b0, sci}, 32'h1);
    @(negedge clk) gpe_evt = 1'b0;
    #1 check("R9 gpe term released", {31'b0, sci}, 32'h0);

    // R11: wake and clear in the same cycle
    @(negedge clk);
    wake_req = 1'b1; wake_src = 2'd0;
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 4'd0; bus_size = 2'b01; bus_wdata = 32'h0400;
    @(negedge clk);
    wake_req = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
    rd(4'd0, 2'b01, d); check("R11 set wins over clear", d, 32'h8400);
    wr(4'd0, 2'b01, 32'hFFFF);

    // R4 R5 R6: timer with 64-tick step
    tick_n(63);
    rd(4'd8, 2'b10, d); check("R4 count after 63 ticks", d, 32'd63);
    @(negedge clk);
    rd(4'd0, 2'b01, d); check("R5 no status below boundary", d, 32'h0);
    tick_n(1);
    @(negedge clk);
    rd(4'd0, 2'b01, d); check("R5 status at boundary", d, 32'h0001);
    tick_n(36);
    wr(4'd0, 2'b01, 32'h0001);
    rd(4'd0, 2'b01, d); check("R6 clear past boundary stays clear", d, 32'h0);
    repeat (3) @(negedge clk);
    rd(4'd0, 2'b01, d); check("R6 no refire from old boundary", d, 32'h0);
    tick_n(27);
    @(negedge clk);
    rd(4'd0, 2'b01, d); check("R6 quiet one tick before new boundary", d, 32'h0);
    tick_n(1);
    @(negedge clk);
    rd(4'd0, 2'b01, d); check("R6 status at re-armed boundary", d, 32'h0001);
    wr(4'd8, 2'b10, 32'hFFFF_FFFF);
    rd(4'd8, 2'b10, d); check("R4 timer write ignored", d, 32'd128);
    wr(4'd2, 2'b01, 32'h0001);
    check("R9 timer status enabled raises sci", {31'b0, sci}, 32'h1);

    @(negedge clk) rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    rd(4'd0, 2'b01, d); check("R10 status cleared by reset", d, 32'h0);
    rd(4'd2, 2'b01, d); check("R10 enable cleared by reset", d, 32'h0);
    rd(4'd8, 2'b10, d); check("R10 counter cleared by reset", d, 32'h0);

    finish_run();
  end
endmodule